// File: doc/BRIEF.md
# Keyed Two-Owner Pump Semaphore

This block arbitrates one shared flash charge pump between two processor-side flash wrappers. Each wrapper has its own register-write port. A write counts only if its upper half-word carries a fixed 16-bit key. The lower half-word then holds an ownership code. Requester A uses code 2 and requester B uses code 1. Code 0 asks for a release.

A wrapper claims the pump by writing the key and its own code again and again. Between writes it reads back the registered ownership field, and it stops once that field shows its own code. It releases the pump by writing the key with a zero code. Both wrappers see the same read-back value.

The semaphore can only change hands through the free state. A claim is honoured only while the semaphore is free. A release is honoured only when it comes from the current owner. If both sides claim a free semaphore in the same cycle, requester A wins.

Top module: `pump_sem_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the ownership output `owner_o` is 0 (free).
- R2: A write has no effect when its enable is low or when data bits 31:16 differ from 0x5A5A.
- R3: When the semaphore is free, a keyed write on port A with low half-word 0x0002 makes `owner_o` equal 2 after the next clock edge. A keyed write on port B with low half-word 0x0001 makes it 1.
- R4: A claim on one port is ignored while the other port holds the semaphore.
- R5: A keyed write with low half-word 0x0000 frees the semaphore only when it comes from the current owner's port. A release from the other port, or while the semaphore is free, is ignored.
- R6: When both ports make a valid claim on a free semaphore in the same cycle, port A (code 2) wins.
- R7: A keyed write whose low half-word is neither 0 nor the port's own code is ignored. This covers 3, the other port's code, and any value with bits 15:2 set. `owner_o` never takes the value 3.
- R8: A repeated claim by the current owner leaves the ownership unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a_wr | input | 1 | Write strobe of requester A |
| req_a_data | input | 32 | Write data of requester A: key in bits 31:16, code in 15:0 |
| req_b_wr | input | 1 | Write strobe of requester B |
| req_b_data | input | 32 | Write data of requester B: key in bits 31:16, code in 15:0 |
| owner_o | output | 2 | Current owner: 0 free, 1 requester B, 2 requester A |

## Verification
Each write acts at the rising edge on which it is presented. Its effect on `owner_o` is visible right after that edge, so a write has exactly one cycle of latency, and the reset value appears one edge after reset is applied.

The bench drives the strobes on the falling edge and holds them through one rising edge. It samples `owner_o` one nanosecond after that edge and then drops the strobes. It sweeps every start owner against every pair of port actions: idle, wrong key, and codes 0, 1, 2, 3 and 0x0102. A behavioural model in the bench gives the expected owner for each case.

// File: rtl/pump_sem_pkg.sv
package pump_sem_pkg;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_REQ_B = 2'd1,
        OWN_REQ_A = 2'd2
    } owner_e;

    typedef struct packed {
        logic claim;
        logic rel;
    } sem_req_t;

    // Ownership moves only through the free state; port A has priority.
    function automatic owner_e next_owner(owner_e cur, sem_req_t ra, sem_req_t rb);
        owner_e nxt;
        nxt = cur;
        case (cur)
            OWN_FREE: begin
                if (ra.claim)      nxt = OWN_REQ_A;
                else if (rb.claim) nxt = OWN_REQ_B;
            end
            OWN_REQ_A: if (ra.rel) nxt = OWN_FREE;
            OWN_REQ_B: if (rb.rel) nxt = OWN_FREE;
            default:   nxt = OWN_FREE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pump_sem_decode.sv
module pump_sem_decode
    import pump_sem_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              KEY_W    = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h5A5A,
    parameter owner_e          OWN_CODE = OWN_REQ_A
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output sem_req_t          req
);
    localparam int FIELD_W = DATA_W - KEY_W;

    logic               key_ok;
    logic [FIELD_W-1:0] field;

    assign key_ok    = wr_en && (wr_data[DATA_W-1 -: KEY_W] == KEY_VAL);
    assign field     = wr_data[FIELD_W-1:0];
    assign req.claim = key_ok && (field == FIELD_W'(OWN_CODE));
    assign req.rel   = key_ok && (field == '0);
endmodule

// File: rtl/pump_sem_core.sv
module pump_sem_core
    import pump_sem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sem_req_t req_a,
    input  sem_req_t req_b,
    output owner_e   owner_q
);
    owner_e owner_d;

    always_comb owner_d = next_owner(owner_q, req_a, req_b);

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_FREE;
        else     owner_q <= owner_d;
    end
endmodule

// File: rtl/pump_sem_arbiter.sv
module pump_sem_arbiter
    import pump_sem_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter int               KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h5A5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_a_wr,
    input  logic [DATA_W-1:0] req_a_data,
    input  logic              req_b_wr,
    input  logic [DATA_W-1:0] req_b_data,
    output logic [1:0]        owner_o
);
    localparam int N_PORTS = 2;

    logic              wr_v   [N_PORTS];
    logic [DATA_W-1:0] data_v [N_PORTS];
    sem_req_t          req_v  [N_PORTS];
    owner_e            owner_q;

    assign wr_v[0]   = req_a_wr;
    assign wr_v[1]   = req_b_wr;
    assign data_v[0] = req_a_data;
    assign data_v[1] = req_b_data;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        pump_sem_decode #(
            .DATA_W  (DATA_W),
            .KEY_W   (KEY_W),
            .KEY_VAL (KEY_VAL),
            .OWN_CODE((g == 0) ? OWN_REQ_A : OWN_REQ_B)
        ) dec_i (
            .wr_en  (wr_v[g]),
            .wr_data(data_v[g]),
            .req    (req_v[g])
        );
    end

    pump_sem_core core_i (
        .clk    (clk),
        .rst    (rst),
        .req_a  (req_v[0]),
        .req_b  (req_v[1]),
        .owner_q(owner_q)
    );

    assign owner_o = owner_q;
endmodule

// File: rtl/pump_sem_checker.sv
module pump_sem_checker #(
    parameter int               DATA_W  = 32,
    parameter int               KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h5A5A
) (
    input logic              clk,
    input logic              rst,
    input logic              req_a_wr,
    input logic [DATA_W-1:0] req_a_data,
    input logic              req_b_wr,
    input logic [DATA_W-1:0] req_b_data,
    input logic [1:0]        owner_o
);
    localparam int LOW_W = DATA_W - KEY_W;

    logic a_keyed, b_keyed, a_claim, b_claim, a_free_req, b_free_req;

    assign a_keyed    = req_a_wr && req_a_data[DATA_W-1 -: KEY_W] == KEY_VAL;
    assign b_keyed    = req_b_wr && req_b_data[DATA_W-1 -: KEY_W] == KEY_VAL;
    assign a_claim    = a_keyed && req_a_data[LOW_W-1:0] == LOW_W'(2);
    assign b_claim    = b_keyed && req_b_data[LOW_W-1:0] == LOW_W'(1);
    assign a_free_req = a_keyed && req_a_data[LOW_W-1:0] == '0;
    assign b_free_req = b_keyed && req_b_data[LOW_W-1:0] == '0;

    a_r1_reset_free: assert property (@(posedge clk) rst |=> owner_o == 2'd0);

    a_r2_unkeyed_hold: assert property (@(posedge clk) disable iff (rst)
        !(a_keyed || b_keyed) |=> $stable(owner_o));

    a_r3_claim_b: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd0 && b_claim && !a_claim) |=> owner_o == 2'd1);

    a_r4_hold_a: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd2 && !a_free_req) |=> owner_o == 2'd2);

    a_r4_hold_b: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd1 && !b_free_req) |=> owner_o == 2'd1);

    a_r5_release_a: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd2 && a_free_req) |=> owner_o == 2'd0);

    a_r6_a_priority: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd0 && a_claim) |=> owner_o == 2'd2);

    a_r7_no_code3: assert property (@(posedge clk) disable iff (rst)
        owner_o != 2'd3);
endmodule

bind pump_sem_arbiter pump_sem_checker #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .KEY_VAL(KEY_VAL)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_a_wr  (req_a_wr),
    .req_a_data(req_a_data),
    .req_b_wr  (req_b_wr),
    .req_b_data(req_b_data),
    .owner_o   (owner_o)
);

// File: tb/pump_sem_arbiter_tb.sv
module pump_sem_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_wr = 1'b0, b_wr = 1'b0;
    logic [31:0] a_data = '0, b_data = '0;
    logic [1:0]  owner;
    int          total = 0, bad = 0;

    always #2 clk = ~clk;

    pump_sem_arbiter dut_i (
        .clk(clk), .rst(rst),
        .req_a_wr(a_wr), .req_a_data(a_data),
        .req_b_wr(b_wr), .req_b_data(b_data),
        .owner_o(owner)
    );

    // Actions: 0 idle (strobe low, valid own claim on data), 1 wrong key,
    // 2..5 key with low half 0..3, 6 key with low half 0x0102.
    localparam int N_ACT = 7;

    function automatic logic [31:0] act_data(int act, int own);
        case (act)
            0:       return {16'h5A5A, 16'(own)};
            1:       return {16'hA5A5, 16'(own)};
            6:       return {16'h5A5A, 16'h0102};
            default: return {16'h5A5A, 16'(act - 2)};
        endcase
    endfunction

    function automatic int model(int s, int aa, int ba);
        bit ac, ar, bc, br;
        ac = (aa == 4); ar = (aa == 2);
        bc = (ba == 3); br = (ba == 2);
        case (s)
            0:       return ac ? 2 : (bc ? 1 : 0);
            2:       return ar ? 0 : 2;
            default: return br ? 0 : 1;
        endcase
    endfunction

    function automatic string tag(int s, int aa, int ba);
        if (s == 0 && aa == 4 && ba == 3) return "R6";
        if (aa == 5 || aa == 6 || aa == 3 || ba == 5 || ba == 6 || ba == 4) return "R7";
        if (aa <= 1 && ba <= 1) return "R2";
        if ((s == 2 && ba == 3) || (s == 1 && aa == 4)) return "R4";
        if (aa == 2 || ba == 2) return "R5";
        if ((s == 2 && aa == 4) || (s == 1 && ba == 3)) return "R8";
        return "R3";
    endfunction

    task automatic check(int got, int exp, string req);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: owner=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic step(int aa, int ba);
        @(negedge clk);
        a_wr = (aa != 0); a_data = act_data(aa, 2);
        b_wr = (ba != 0); b_data = act_data(ba, 1);
        @(posedge clk);
        #1;
        a_wr = 1'b0; b_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(int'(owner), 0, "R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(int'(owner), 0, "R1");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: owner=%0d expected=done", owner);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        for (int s = 0; s < 3; s++) begin
            for (int aa = 0; aa < N_ACT; aa++) begin
                for (int ba = 0; ba < N_ACT; ba++) begin
                    do_reset();
                    if (s == 2) step(4, 0);
                    if (s == 1) step(0, 3);
                    check(int'(owner), s, "R3");
                    step(aa, ba);
                    check(int'(owner), model(s, aa, ba), tag(s, aa, ba));
                end
            end
        end
        // Polling sequence: B holds, A keeps claiming, B releases, A gets it.
        do_reset();
        step(0, 3);
        step(4, 0);  check(int'(owner), 1, "R4");
        step(4, 2);  check(int'(owner), 0, "R5");
        step(4, 0);  check(int'(owner), 2, "R3");
        step(4, 0);  check(int'(owner), 2, "R8");
        step(0, 2);  check(int'(owner), 2, "R5");
        step(2, 0);  check(int'(owner), 0, "R5");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule